// File: doc/BRIEF.md
# Memory-Reference Operand Address Generator

This block turns the addressing part of a 16-bit memory-reference instruction into the address of its operand. The inputs are an 8-bit address field, three mode bits, a direction/select bit, a word-or-byte granularity flag, the program counter (a word address) and the 16-bit index register. From these it forms a scratchpad, relative or indexed address. When the indirect bit is set, it also reads address pointers from memory. The result is a 15-bit word address and a byte-select bit, marked by a one-cycle `done` pulse.

A direct address takes one clock. An indirect address reads one or more pointer words through a request/valid read port. In word mode a pointer can name another pointer, so the walk can chain. A level limit ends a self-referencing chain with an error flag. In byte mode exactly one pointer is read. The index register is added after the pointer has been resolved.

Top module: `mref_ea_gen`

## Requirements
- R1: After a synchronous active-low reset, `done`, `err`, `rd_req`, `ea_word`, `ea_bsel` and `rd_addr` are all 0.
- R2: `mode_bits[2]` selects indirect, `mode_bits[1]` adds the index register, and `mode_bits[0]` selects relative (0 means scratchpad). A start accepted while idle with `mode_bits[2]=0` gives `done=1` for exactly one cycle, in the cycle after the start edge. `err` is then 0.
- R3: In scratchpad mode, the 8-bit field zero-extended is the word address (word mode) or the byte address (byte mode). A byte address B appears as `ea_word=B[15:1]` and `ea_bsel=B[0]`, where `ea_bsel=0` selects the high byte. In word mode `ea_bsel` is 0.
- R4: In word mode, relative with `dir_sel=0` gives pc+1+field. With `dir_sel=1` it gives pc-field. Both wrap modulo 2^15.
- R5: In byte mode, relative addressing only goes forward. The byte address is {pc+1+field (mod 2^15), dir_sel}, so `dir_sel` acts as the byte select.
- R6: When `mode_bits[1]=1`, the index register is added to the scratchpad or relative result. The sum wraps modulo 2^15 for a word address and modulo 2^16 for a byte address.
- R7: In word-mode indirect, the first pointer is read at the word address given by R3/R4. A pointer with bit 15 set causes a further read at its bits 14:0. The result is bits 14:0 of the last pointer, plus the index register when `mode_bits[1]=1` (modulo 2^15).
- R8: In byte-mode indirect, the pointer word address is the scratchpad field or pc+1+field (`dir_sel` is ignored). Exactly one read is made. The result is the 16-bit pointer, plus the index register when selected, used as the byte address.
- R9: In word mode at most 16 pointer reads are made. If the 16th pointer still has bit 15 set, `done` and `err` pulse together. The address is then formed from that pointer as in R7. `err` is never 1 without `done`.
- R10: `rd_req` stays high with `rd_addr` unchanged until a cycle with `rd_valid=1`. `rd_data` is taken in that cycle.
- R11: While an indirect walk is in progress, `start` is ignored.
- R12: The index register, the index bit and the byte flag are captured at the accepted start. Changing those inputs during a walk does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an address computation |
| addr_fld | input | 8 | Instruction address field |
| mode_bits | input | 3 | Indirect, index and relative select |
| dir_sel | input | 1 | Backward (word mode) or byte select (byte relative) |
| byte_mode | input | 1 | 1 = byte granularity |
| pc | input | 15 | Word address of the instruction |
| xreg | input | 16 | Index register |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 15 | Pointer word address |
| rd_valid | input | 1 | Pointer data valid |
| rd_data | input | 16 | Pointer word |
| ea_word | output | 15 | Resulting word address |
| ea_bsel | output | 1 | Byte select, 0 = high byte |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Indirection limit reached |

## Verification
A direct result is registered at the clock edge that accepts `start`, so the bench checks `done` and the address at the falling edge right after that edge. It then checks that `done` has dropped one cycle later. An indirect result follows the final `rd_valid` by one edge. The read port is modelled with a random latency of 0 to 2 cycles, so the bench polls `done` at each falling edge and compares the address, the error flag and the number of reads served. In the first cycle of a walk, `start` is pulsed again and the index register and the byte flag are scrambled; they are left scrambled until `done`, to show they have no effect.

// File: rtl/mref_ea_pkg.sv
// Shared types for the memory-reference address generator.
// Assumes: a single clock domain; no other package defines these names.
package mref_ea_pkg;
    // Width of a word address for the default configuration.
    localparam int unsigned DEF_WAW = 15;

    // Pointer-walk controller state.
    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_WAIT = 1'b1
    } walk_st_t;
endpackage

// File: rtl/mref_ea_base.sv
// Base address former: computes the scratchpad or relative word address
// and the matching byte address from the field and the program counter.
// Assumes: purely combinational; all sums wrap at the address width.
module mref_ea_base #(
    parameter int unsigned WAW = 15,
    parameter int unsigned FW  = 8
) (
    input  logic [FW-1:0]  fld,
    input  logic [WAW-1:0] pc,
    input  logic           rel,
    input  logic           back,
    input  logic           bytem,
    output logic [WAW-1:0] word_base,
    output logic [WAW:0]   byte_base
);
    logic [WAW-1:0] fld_w;
    logic [WAW-1:0] fwd_w;
    logic [WAW-1:0] bwd_w;

    // Forward and backward relative word sums.
    always_comb begin
        fld_w = WAW'(fld);
        fwd_w = pc + WAW'(1) + fld_w;
        bwd_w = pc - fld_w;
    end

    // Word base: backward only in word mode; byte mode forces forward.
    always_comb begin
        if (!rel)
            word_base = fld_w;
        else if (back && !bytem)
            word_base = bwd_w;
        else
            word_base = fwd_w;
    end

    // Byte base: relative puts the direction bit into the select position.
    always_comb begin
        if (rel)
            byte_base = {fwd_w, back};
        else
            byte_base = (WAW+1)'(fld);
    end
endmodule

// File: rtl/mref_ea_idx_add.sv
// Post-index adder: adds the index value to an address when enabled.
// Assumes: the result wraps modulo 2^W.
module mref_ea_idx_add #(
    parameter int unsigned W = 15
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] xval,
    input  logic         en,
    output logic [W-1:0] sum
);
    // Conditional modular addition of the index.
    always_comb sum = base + (en ? xval : '0);
endmodule

// File: rtl/mref_ea_walk.sv
// Pointer walker: issues pointer reads over a request/valid port and
// follows further-indirect pointers in word mode up to MAX_LVL reads.
// Assumes: rd_valid is only given while rd_req is high; bytem is stable
// for the whole walk (the top captures it at start).
module mref_ea_walk
    import mref_ea_pkg::*;
#(
    parameter int unsigned WAW     = 15,
    parameter int unsigned MAX_LVL = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [WAW-1:0] ptr_addr,
    input  logic           bytem,
    input  logic           rd_valid,
    input  logic [WAW:0]   rd_data,
    output logic           rd_req,
    output logic [WAW-1:0] rd_addr,
    output logic           busy,
    output logic           fin,
    output logic           fin_err
);
    localparam int unsigned DW   = WAW + 1;
    localparam int unsigned LVLW = $clog2(MAX_LVL + 1);

    walk_st_t        st;
    logic [LVLW-1:0] lvl;
    logic            more;

    // Decide whether the returned pointer leads to another read.
    always_comb begin
        more    = !bytem && rd_data[DW-1] && (lvl < LVLW'(MAX_LVL));
        busy    = (st == WK_WAIT);
        fin     = busy && rd_valid && !more;
        fin_err = fin && !bytem && rd_data[DW-1];
    end

    // Walk state, request line, read address and level count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= WK_IDLE;
            rd_req  <= 1'b0;
            rd_addr <= '0;
            lvl     <= '0;
        end else begin
            case (st)
                WK_IDLE: begin
                    if (go) begin
                        st      <= WK_WAIT;
                        rd_req  <= 1'b1;
                        rd_addr <= ptr_addr;
                        lvl     <= LVLW'(1);
                    end
                end
                WK_WAIT: begin
                    if (rd_valid) begin
                        if (more) begin
                            rd_addr <= rd_data[WAW-1:0];
                            lvl     <= lvl + LVLW'(1);
                        end else begin
                            st     <= WK_IDLE;
                            rd_req <= 1'b0;
                        end
                    end
                end
                default: st <= WK_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R10
    AST_LVL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lvl >= LVLW'(1)) && (lvl <= LVLW'(MAX_LVL))); // R9
    AST_BYTE_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_valid && bytem |=> !rd_req); // R8
endmodule

// File: rtl/mref_ea_gen.sv
// Memory-reference operand address generator (top).
// Forms scratchpad, relative, indexed and indirect addresses in word or
// byte granularity; returns a word address, a byte select and done.
// Assumes: start is a one-cycle request; inputs are valid with start.
module mref_ea_gen
    import mref_ea_pkg::*;
#(
    parameter int unsigned WAW     = DEF_WAW,
    parameter int unsigned FW      = 8,
    parameter int unsigned MAX_LVL = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [FW-1:0]  addr_fld,
    input  logic [2:0]     mode_bits,
    input  logic           dir_sel,
    input  logic           byte_mode,
    input  logic [WAW-1:0] pc,
    input  logic [WAW:0]   xreg,
    output logic           rd_req,
    output logic [WAW-1:0] rd_addr,
    input  logic           rd_valid,
    input  logic [WAW:0]   rd_data,
    output logic [WAW-1:0] ea_word,
    output logic           ea_bsel,
    output logic           done,
    output logic           err
);
    localparam int unsigned DW = WAW + 1;

    logic           busy, fin, fin_err;
    logic           accept, direct_go, ind_go;
    logic [WAW-1:0] word_base;
    logic [DW-1:0]  byte_base;
    logic [DW-1:0]  lat_x;
    logic           lat_idx, lat_bm;
    logic [DW-1:0]  x_sel;
    logic           idx_sel, bm_sel;
    logic [WAW-1:0] word_in, word_sum;
    logic [DW-1:0]  byte_in, byte_sum;

    // Start acceptance: only while no walk is in progress.
    always_comb begin
        accept    = start && !busy;
        direct_go = accept && !mode_bits[2];
        ind_go    = accept && mode_bits[2];
    end

    // Capture index, index enable and granularity for an indirect walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_x   <= '0;
            lat_idx <= 1'b0;
            lat_bm  <= 1'b0;
        end else if (accept) begin
            lat_x   <= xreg;
            lat_idx <= mode_bits[1];
            lat_bm  <= byte_mode;
        end
    end

    // Operand selection: live inputs when direct, captured ones when walking.
    always_comb begin
        x_sel   = busy ? lat_x   : xreg;
        idx_sel = busy ? lat_idx : mode_bits[1];
        bm_sel  = busy ? lat_bm  : byte_mode;
        word_in = fin ? rd_data[WAW-1:0] : word_base;
        byte_in = fin ? rd_data          : byte_base;
    end

    mref_ea_base #(.WAW(WAW), .FW(FW)) u_base (
        .fld       (addr_fld),
        .pc        (pc),
        .rel       (mode_bits[0]),
        .back      (dir_sel),
        .bytem     (byte_mode),
        .word_base (word_base),
        .byte_base (byte_base)
    );

    mref_ea_walk #(.WAW(WAW), .MAX_LVL(MAX_LVL)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (ind_go),
        .ptr_addr (word_base),
        .bytem    (lat_bm),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .busy     (busy),
        .fin      (fin),
        .fin_err  (fin_err)
    );

    mref_ea_idx_add #(.W(WAW)) u_add_word (
        .base (word_in),
        .xval (x_sel[WAW-1:0]),
        .en   (idx_sel),
        .sum  (word_sum)
    );

    mref_ea_idx_add #(.W(DW)) u_add_byte (
        .base (byte_in),
        .xval (x_sel),
        .en   (idx_sel),
        .sum  (byte_sum)
    );

    // Result registers: address, byte select, done and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_word <= '0;
            ea_bsel <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= direct_go || fin;
            err  <= fin && fin_err;
            if (direct_go || fin) begin
                if (bm_sel) begin
                    ea_word <= byte_sum[DW-1:1];
                    ea_bsel <= byte_sum[0];
                end else begin
                    ea_word <= word_sum;
                    ea_bsel <= 1'b0;
                end
            end
        end
    end

    AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !mode_bits[2] |=> done); // R2
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R9
    AST_NO_REQ_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !mode_bits[2] |=> !rd_req); // R11
endmodule

// File: tb/sim_mref_ea_gen.sv
module sim_mref_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  addr_fld = '0;
    logic [2:0]  mode_bits = '0;
    logic        dir_sel = 1'b0;
    logic        byte_mode = 1'b0;
    logic [14:0] pc = '0;
    logic [15:0] xreg = '0;
    logic        rd_req;
    logic [14:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic [14:0] ea_word;
    logic        ea_bsel, done, err;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int lat    = 0;
    int mkind  = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mref_ea_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_fld(addr_fld),
        .mode_bits(mode_bits), .dir_sel(dir_sel), .byte_mode(byte_mode),
        .pc(pc), .xreg(xreg), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .ea_word(ea_word),
        .ea_bsel(ea_bsel), .done(done), .err(err)
    );

    // Memory contents: 0 hash, 1 self-pointing, 2 counted chain.
    function automatic logic [15:0] memf(input int kind, input logic [14:0] a);
        logic [31:0] h;
        if (kind == 1) return {1'b1, a};
        if (kind == 2) return (a[4:0] != 5'd0) ? {1'b1, a - 15'd1} : {1'b0, a ^ 15'h1234};
        h = (32'(a) * 32'd40503 + 32'h5bd1) ^ (32'(a) >> 3);
        return {h[15] & h[14], h[13:0], h[16]};
    endfunction

    // Read port responder with 0..2 cycles of latency.
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_valid = 1'b0;
            lat = $urandom_range(0, 2);
        end else if (rd_req) begin
            if (lat == 0) begin
                rd_data  = memf(mkind, rd_addr);
                rd_valid = 1'b1;
                reads++;
            end else begin
                lat--;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int got, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, expv);
        end
    endtask

    // Expected result derived from the requirements.
    task automatic model(input logic [7:0] f, input logic [2:0] m, input logic d,
                         input logic bm, input logic [14:0] p, input logic [15:0] x,
                         output logic [14:0] ew, output logic eb, output logic ee,
                         output int nr);
        logic [14:0] fw, a;
        logic [15:0] ba, dat;
        fw = p + 15'd1 + {7'd0, f};
        ee = 1'b0; nr = 0; dat = '0;
        if (!m[2]) begin
            if (bm) begin
                ba = (m[0] ? {fw, d} : {8'd0, f}) + (m[1] ? x : 16'd0);
                ew = ba[15:1]; eb = ba[0];
            end else begin
                a  = m[0] ? (d ? p - {7'd0, f} : fw) : {7'd0, f};
                ew = a + (m[1] ? x[14:0] : 15'd0); eb = 1'b0;
            end
        end else begin
            a = m[0] ? ((d && !bm) ? p - {7'd0, f} : fw) : {7'd0, f};
            for (int lv = 1; lv <= 16; lv++) begin
                dat = memf(mkind, a);
                nr  = lv;
                if (!bm && dat[15] && lv < 16) a = dat[14:0];
                else break;
            end
            ee = !bm && dat[15];
            if (bm) begin
                ba = dat + (m[1] ? x : 16'd0);
                ew = ba[15:1]; eb = ba[0];
            end else begin
                ew = dat[14:0] + (m[1] ? x[14:0] : 15'd0); eb = 1'b0;
            end
        end
    endtask

    task automatic run_op(input logic [7:0] f, input logic [2:0] m, input logic d,
                          input logic bm, input logic [14:0] p, input logic [15:0] x,
                          input bit disturb, input string req);
        logic [14:0] ew; logic eb, ee; int nr; int waited;
        model(f, m, d, bm, p, x, ew, eb, ee, nr);
        @(negedge clk);
        reads = 0;
        addr_fld = f; mode_bits = m; dir_sel = d; byte_mode = bm; pc = p; xreg = x;
        start = 1'b1;
        @(negedge clk);
        if (!m[2]) begin
            start = 1'b0;
            chk(done === 1'b1, {req, " done"}, done, 1);
            chk(ea_word === ew, {req, " word"}, ea_word, ew);
            chk(ea_bsel === eb, {req, " bsel"}, ea_bsel, eb);
            chk(err === 1'b0, {req, " err"}, err, 0);
            @(negedge clk);
            chk(done === 1'b0, "R2 done pulse", done, 0);
        end else begin
            chk(done === 1'b0, {req, " early done"}, done, 0);
            if (disturb) begin            // R11 R12: restart and scrambled inputs
                start = 1'b1; xreg = ~x; byte_mode = ~bm;
                mode_bits = {1'b0, ~m[1], m[0]};
            end else start = 1'b0;
            waited = 0;
            while (waited < 200) begin
                @(negedge clk);
                start = 1'b0;
                waited++;
                if (done === 1'b1) break;
            end
            chk(done === 1'b1, {req, " done"}, done, 1);
            chk(ea_word === ew, {req, " word"}, ea_word, ew);
            chk(ea_bsel === eb, {req, " bsel"}, ea_bsel, eb);
            chk(err === ee, {req, " err"}, err, ee);
            chk(reads == nr, {req, " reads"}, reads, nr);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done === 1'b0, "R1 done", done, 0);
        chk(err === 1'b0, "R1 err", err, 0);
        chk(rd_req === 1'b0, "R1 rd_req", rd_req, 0);
        chk(ea_word === 15'd0, "R1 ea_word", ea_word, 0);
        chk(ea_bsel === 1'b0, "R1 ea_bsel", ea_bsel, 0);
        chk(rd_addr === 15'd0, "R1 rd_addr", rd_addr, 0);

        // Directed corner cases
        run_op(8'hFF, 3'b000, 1'b0, 1'b0, 15'h0100, 16'h0, 0, "R3 scratch word");
        run_op(8'h37, 3'b000, 1'b0, 1'b1, 15'h0100, 16'h0, 0, "R3 scratch byte");
        run_op(8'h00, 3'b001, 1'b0, 1'b0, 15'h7FFF, 16'h0, 0, "R4 fwd wrap");
        run_op(8'hFF, 3'b001, 1'b1, 1'b0, 15'h0005, 16'h0, 0, "R4 back wrap");
        run_op(8'h02, 3'b001, 1'b1, 1'b1, 15'h0010, 16'h0, 0, "R5 byte rel select");
        run_op(8'hFF, 3'b001, 1'b0, 1'b1, 15'h7FFF, 16'h0, 0, "R5 byte rel wrap");
        run_op(8'h01, 3'b010, 1'b0, 1'b0, 15'h0000, 16'hFFFF, 0, "R6 index word wrap");
        run_op(8'h01, 3'b010, 1'b0, 1'b1, 15'h0000, 16'hFFFF, 0, "R6 index byte wrap");
        mkind = 2;
        run_op(8'h2F, 3'b100, 1'b0, 1'b0, 15'h0, 16'h0, 0, "R7 chain sixteen");
        run_op(8'h30, 3'b100, 1'b0, 1'b0, 15'h0, 16'h0, 0, "R9 chain limit");
        mkind = 1;
        run_op(8'h05, 3'b110, 1'b0, 1'b0, 15'h0, 16'h0100, 1, "R9 self loop");
        run_op(8'h05, 3'b111, 1'b1, 1'b1, 15'h0200, 16'h0003, 1, "R8 byte single");
        mkind = 0;
        run_op(8'h10, 3'b111, 1'b1, 1'b0, 15'h0040, 16'h1234, 1, "R12 latched index");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] m;
            m = 3'($urandom_range(0, 7));
            run_op(8'($urandom), m, 1'($urandom), 1'($urandom), 15'($urandom),
                   16'($urandom), 1'($urandom),
                   m[2] ? (m[1] ? "R7 R8 R10 random indirect" : "R10 random indirect")
                        : "R6 random direct");
        end

        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule